// File: doc/BRIEF.md
# Lattice Public-Key Row Generator

This block produces the second half of a learning-with-errors public key, one element per row of the random matrix. An upstream source hands over complete rows of the matrix, each row in a single transfer on a wide bus. For every accepted row the block multiplies it element by element with a secret vector that is held on an input port, and sums the products. It then adds a small signed noise value and reduces the total modulo a run-time modulus. The result leaves on a data port together with a one-cycle strobe.

The noise is approximately bell-shaped. It is built by adding four 4-bit fields taken from a free-running linear-feedback shift register and removing the mean of that sum, so each sample lies between -30 and +30. The vector length and the number of rows are run-time inputs. Once the last row has been reduced the block raises a completion flag and holds everything still until reset is asserted again.

Top module: `lwe_brow_gen`

## Requirements
- R1: While `rst_n` is low, `row_ready`, `b_valid` and `done` are 0. On the first rising clock edge after `rst_n` goes high, `row_ready` rises, provided `rows_total` is nonzero.
- R2: A row is taken on a rising edge where both `row_valid` and `row_ready` are 1. `row_ready` drops on the next cycle and stays low until that row's result has been emitted. A `row_valid` that is presented while `row_ready` is low is ignored.
- R3: Each result is `(sum over k < size_n of a[k]*s[k] + e) mod q`. Here `e` is an integer in [-30, +30] and `q` lies between 32 and 65535. The result is always less than `q`. Element k of `row_data` and of `s_vec` occupies bits [16k+15 : 16k].
- R4: Elements at index `size_n` and above in `row_data` and `s_vec` have no effect on the result.
- R5: When the sum plus the noise is negative, `q` is added before the reduction. With `size_n` = 0 the result is therefore `e` when `e` >= 0, and `q + e` when `e` is negative.
- R6: The noise is the sum of four 4-bit fields of a 16-bit LFSR minus 30. The LFSR advances on every cycle in which the block is not finished, so successive rows receive differing noise.
- R7: Exactly one `b_valid` pulse is produced per accepted row, in order of acceptance. `done` is 0 during every pulse and rises on the cycle after the pulse for row `rows_total`.
- R8: After `done` rises, it stays high until reset. `row_ready` and `b_valid` stay low, `b_data` keeps its value, and any offered rows are ignored.
- R9: With `rows_total` = 0, `done` rises on the first clock edge after reset release and no result is produced.
- R10: Full-width elements (0xFFFF) at the maximum length of 63 accumulate without overflow and give a correct residue for `q` = 65521.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| q | input | 16 | Modulus, 32 to 65535 |
| size_n | input | 6 | Vector length, 0 to 63 |
| rows_total | input | 6 | Number of matrix rows to process |
| s_vec | input | 1008 | Secret vector, element k at bits [16k+15:16k] |
| row_data | input | 1008 | One matrix row, same element layout |
| row_valid | input | 1 | Upstream offers a row |
| row_ready | output | 1 | Block can take a row this cycle |
| b_data | output | 16 | Public-key element for the latest row |
| b_valid | output | 1 | One-cycle strobe for `b_data` |
| done | output | 1 | All rows processed; block frozen |

## Verification
The bench fills the elements beyond `size_n` with junk. A design that reads past the vector length then gives results far outside the ±30 noise window. It also holds `row_valid` high with junk while the block is busy, so any premature capture shows up as an extra or mismatched result in the scoreboard. A length-zero run exercises the negative-total wrap, which a design that skipped the `q` correction would turn into a huge residue. Across that run the bench also checks that the noise is not constant. An all-ones run at length 63 exposes a truncated accumulator. A reducer whose comparison is off by one leaves a value equal to `q` and is caught by the bound check. Zero rows and the frozen state after completion are checked at the ports.

// File: rtl/lwe_brow_pkg.sv
package lwe_brow_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_MAC,
    ST_ERR,
    ST_RED,
    ST_DONE
  } brow_state_e;
endpackage

// File: rtl/lwe_clt_noise.sv
// Approximately normal noise: sum of NSAMP uniform fields of a Galois LFSR, mean removed.
module lwe_clt_noise #(
  parameter int                LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED   = 16'h1D2B,
  parameter int                NSAMP  = 4,
  parameter int                SAMP_W = 4,
  localparam int               SUM_W  = SAMP_W + $clog2(NSAMP),
  localparam int               ERR_W  = SUM_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  output logic signed [ERR_W-1:0] err
);
  localparam int OFFSET = NSAMP * ((1 << SAMP_W) - 1) / 2;
  localparam logic signed [ERR_W-1:0] OFFS = ERR_W'(OFFSET);

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step)
      lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NSAMP; i++)
      sum = sum + SUM_W'(lfsr_q[i*SAMP_W +: SAMP_W]);
  end

  assign err = $signed({1'b0, sum}) - OFFS;

  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != '0);
  p_lfsr_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> lfsr_q != $past(lfsr_q));
  p_err_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err >= -OFFS) && (err <= OFFS));
endmodule

// File: rtl/lwe_dot_acc.sv
// Multiply-accumulate, one element pair per enabled cycle.
module lwe_dot_acc #(
  parameter int DW    = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DW-1:0]    a_el,
  input  logic [DW-1:0]    s_el,
  output logic [ACC_W-1:0] acc
);
  logic [2*DW-1:0]  prod;
  logic [ACC_W-1:0] acc_q, acc_d;

  assign prod = a_el * s_el;

  always_comb begin
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = acc_q + ACC_W'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  p_acc_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/lwe_mod_shrink.sv
// Shift-and-subtract reduction: largest power-of-two multiple of q removed first.
module lwe_mod_shrink #(
  parameter int DW    = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  input  logic [DW-1:0]    q,
  output logic [DW-1:0]    rem,
  output logic             fin
);
  localparam int SH_W = $clog2(ACC_W);
  localparam int XW   = ACC_W + DW;

  logic [ACC_W-1:0] val_q, val_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic             act_q, act_d, fin_q, fin_d;
  logic [XW-1:0]    qs;
  logic             geq;

  assign qs  = XW'(q) << sh_q;
  assign geq = XW'(val_q) >= qs;

  always_comb begin
    val_d = val_q;
    sh_d  = sh_q;
    act_d = act_q;
    fin_d = 1'b0;
    if (load) begin
      val_d = load_val;
      sh_d  = SH_W'(ACC_W - 1);
      act_d = 1'b1;
    end else if (act_q) begin
      if (geq) val_d = val_q - qs[ACC_W-1:0];
      if (sh_q == '0) begin
        act_d = 1'b0;
        fin_d = 1'b1;
      end else begin
        sh_d = sh_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      sh_q  <= '0;
      act_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      val_q <= val_d;
      sh_q  <= sh_d;
      act_q <= act_d;
      fin_q <= fin_d;
    end
  end

  assign rem = val_q[DW-1:0];
  assign fin = fin_q;

  p_rem_below_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> val_q < ACC_W'(q));
  p_fin_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
endmodule

// File: rtl/lwe_brow_gen.sv
module lwe_brow_gen
  import lwe_brow_pkg::*;
#(
  parameter int DW     = 16,
  parameter int MAX_N  = 63,
  parameter int ACC_W  = 40,
  parameter int NSAMP  = 4,
  parameter int SAMP_W = 4,
  localparam int LEN_W = $clog2(MAX_N + 1),
  localparam int BUS_W = MAX_N * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    q,
  input  logic [LEN_W-1:0] size_n,
  input  logic [LEN_W-1:0] rows_total,
  input  logic [BUS_W-1:0] s_vec,
  input  logic [BUS_W-1:0] row_data,
  input  logic             row_valid,
  output logic             row_ready,
  output logic [DW-1:0]    b_data,
  output logic             b_valid,
  output logic             done
);
  localparam int ERR_W = SAMP_W + $clog2(NSAMP) + 1;

  brow_state_e       state_q, state_d;
  logic [LEN_W-1:0]  idx_q, idx_d, rows_q, rows_d;
  logic [BUS_W-1:0]  row_q, row_d;
  logic              mac_clr, mac_en, red_load, red_fin, step;
  logic [DW-1:0]     a_el, s_el, red_rem;
  logic [ACC_W-1:0]  acc;
  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W:0]   tot, fixd;

  assign a_el = row_q[int'(idx_q)*DW +: DW];
  assign s_el = s_vec[int'(idx_q)*DW +: DW];
  assign step = (state_q != ST_DONE);

  lwe_clt_noise #(.NSAMP(NSAMP), .SAMP_W(SAMP_W)) u_noise (
    .clk(clk), .rst_n(rst_n), .step(step), .err(err)
  );

  lwe_dot_acc #(.DW(DW), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(mac_clr), .en(mac_en),
    .a_el(a_el), .s_el(s_el), .acc(acc)
  );

  // Noise is added before reduction; a negative total is lifted by q.
  always_comb begin
    tot  = $signed({1'b0, acc}) + (ACC_W+1)'(err);
    fixd = tot[ACC_W] ? tot + $signed({{(ACC_W+1-DW){1'b0}}, q}) : tot;
  end

  lwe_mod_shrink #(.DW(DW), .ACC_W(ACC_W)) u_red (
    .clk(clk), .rst_n(rst_n), .load(red_load), .load_val(fixd[ACC_W-1:0]),
    .q(q), .rem(red_rem), .fin(red_fin)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    rows_d   = rows_q;
    row_d    = row_q;
    mac_clr  = 1'b0;
    mac_en   = 1'b0;
    red_load = 1'b0;
    case (state_q)
      ST_INIT: state_d = (rows_total == '0) ? ST_DONE : ST_IDLE;
      ST_IDLE: if (row_valid) begin
        row_d   = row_data;
        idx_d   = '0;
        mac_clr = 1'b1;
        state_d = (size_n == '0) ? ST_ERR : ST_MAC;
      end
      ST_MAC: begin
        mac_en = 1'b1;
        if (idx_q == size_n - 1'b1) state_d = ST_ERR;
        else                        idx_d   = idx_q + 1'b1;
      end
      ST_ERR: begin
        red_load = 1'b1;
        state_d  = ST_RED;
      end
      ST_RED: if (red_fin) begin
        rows_d  = rows_q + 1'b1;
        state_d = (rows_q + 1'b1 == rows_total) ? ST_DONE : ST_IDLE;
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      idx_q   <= '0;
      rows_q  <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rows_q  <= rows_d;
      row_q   <= row_d;
    end
  end

  assign row_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign b_valid   = red_fin;
  assign b_data    = red_rem;

  p_accept_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_ready) |=> !row_ready);
  p_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERR) |-> !fixd[ACC_W]);
  p_rows_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rows_q <= rows_total);
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!b_valid && !row_ready && $stable(b_data)));
endmodule

// File: tb/sim_lwe_brow_gen.sv
module sim_lwe_brow_gen;
  localparam int DW = 16, MAX_N = 63, LEN_W = 6, BUS_W = MAX_N * DW;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DW-1:0]    q;
  logic [LEN_W-1:0] size_n, rows_total;
  logic [BUS_W-1:0] s_vec, row_data;
  logic             row_valid, row_ready, b_valid, done;
  logic [DW-1:0]    b_data;

  always #2 clk = ~clk;

  lwe_brow_gen u0 (
    .clk(clk), .rst_n(rst_n), .q(q), .size_n(size_n), .rows_total(rows_total),
    .s_vec(s_vec), .row_data(row_data), .row_valid(row_valid),
    .row_ready(row_ready), .b_data(b_data), .b_valid(b_valid), .done(done)
  );

  int     n_tests = 0, n_fail = 0, cyc = 0, out_cnt = 0, q_cur = 97;
  string  mon_req = "R3";
  longint exp_q[$];
  longint bvals[64];
  longint got, e, d;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] a_of(int kind, int r, int k);
    return (kind == 1) ? 16'hFFFF : 16'(r * 4099 + k * 257 + 13);
  endfunction

  function automatic logic [15:0] s_of(int kind, int k);
    return (kind == 1) ? 16'hFFFF : 16'(k * 919 + 7);
  endfunction

  // Scoreboard monitor: result must be the expected residue shifted by at most 30 (mod q).
  always @(negedge clk) begin
    if (rst_n && b_valid) begin
      got = longint'(b_data);
      if (exp_q.size() == 0) chk(1'b0, mon_req, "unexpected result", got, -1);
      else begin
        e = exp_q.pop_front();
        d = (got - e + q_cur) % q_cur;
        chk(got < q_cur && (d <= 30 || d >= q_cur - 30), mon_req,
            "result vs dot mod q", got, e);
      end
      chk(!done, "R7", "done during result", longint'(done), 0);
      if (out_cnt < 64) bvals[out_cnt] = got;
      out_cnt++;
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic send_row(input int r, input int n, input int kind, input bit noisy);
    logic [BUS_W-1:0] rd;
    longint sum = 0;
    for (int k = 0; k < MAX_N; k++) begin
      // R4: junk beyond size_n
      rd[k*DW +: DW] = (k < n) ? a_of(kind, r, k) : (16'hA5A5 ^ 16'(k));
      if (k < n) sum += longint'(a_of(kind, r, k)) * longint'(s_of(kind, k));
    end
    for (int t = 0; t < 10000; t++) begin
      @(negedge clk);
      if (row_ready) begin
        row_data  = rd;
        row_valid = 1'b1;
        exp_q.push_back(sum % q_cur);
        @(negedge clk);
        chk(!row_ready, "R2", "row_ready after accept", longint'(row_ready), 0);
        row_valid = 1'b0;
        return;
      end else if (noisy) begin
        row_valid = 1'b1;
        row_data  = ~rd;
      end else begin
        row_valid = 1'b0;
      end
    end
  endtask

  task automatic run_case(input int qv, input int n, input int m, input int kind,
                          input bit noisy, input string req);
    logic [DW-1:0] hold;
    q_cur = qv; mon_req = req;
    rst_n = 1'b0; row_valid = 1'b0; row_data = '0;
    q = 16'(qv); size_n = LEN_W'(n); rows_total = LEN_W'(m);
    for (int k = 0; k < MAX_N; k++)
      s_vec[k*DW +: DW] = (k < n) ? s_of(kind, k) : (16'h5A5A + 16'(k));
    out_cnt = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk(!row_ready && !b_valid && !done, "R1", "outputs in reset",
        longint'({row_ready, b_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    if (m == 0) chk(done && !row_ready, "R9", "done at first clock",
                    longint'({done, row_ready}), 2);
    else        chk(row_ready && !done, "R1", "ready at first clock",
                    longint'({row_ready, done}), 2);
    for (int r = 0; r < m; r++) send_row(r, n, kind, noisy);
    for (int t = 0; t < 5000 && !done; t++) @(negedge clk);
    chk(done, "R7", "done after last row", longint'(done), 1);
    chk(out_cnt == m, "R7", "result count", out_cnt, m);
    chk(exp_q.size() == 0, "R7", "pending results", exp_q.size(), 0);
    // R8: frozen after completion, offered rows ignored
    hold = b_data;
    row_valid = 1'b1;
    row_data = {MAX_N{16'h1234}};
    repeat (12) begin
      @(negedge clk);
      chk(done && !row_ready && !b_valid && b_data == hold, "R8", "frozen state",
          longint'(b_data), longint'(hold));
    end
    row_valid = 1'b0;
  endtask

  initial begin
    int uniq;
    rst_n = 1'b0; row_valid = 1'b0; row_data = '0; s_vec = '0;
    q = 16'd97; size_n = '0; rows_total = '0;

    run_case(97, 4, 5, 0, 1'b1, "R3 R4");   // stall junk and junk beyond length (R2, R4)
    run_case(65521, 63, 3, 1, 1'b0, "R10");  // full width, maximum length
    run_case(1009, 0, 6, 0, 1'b0, "R5");     // noise only, negative wrap
    uniq = 0;
    for (int i = 0; i < 6; i++) begin
      bit seen = 1'b0;
      for (int j = 0; j < i; j++) if (bvals[j] == bvals[i]) seen = 1'b1;
      if (!seen) uniq++;
    end
    chk(uniq >= 2, "R6", "distinct noise residues", uniq, 2);
    run_case(97, 5, 0, 0, 1'b0, "R9");
    run_case(211, 7, 4, 0, 1'b1, "R3");

    summary();
    $finish;
  end
endmodule